// File: doc/BRIEF.md
# Byte-Addressed Data Memory Port

This block is a small synchronous data store holding 32-bit words that software addresses by byte. A 2-bit memory control code, qualified by an enable, chooses one of four operations: a word read, a byte store, a halfword store or a word store. Stores drive per-lane byte enables, so a sub-word store changes only the bytes it targets and leaves the rest of the word as it was. Bytes are numbered big-endian inside a word.

On the read side, a load-extraction stage takes the addressed word. It picks out a byte or a halfword by the low address bits and then sign-extends or zero-extends that value to 32 bits, as the load type asks. Read data is combinational from the addressed word. Stores commit on the rising clock edge. A misalignment flag reports halfword or word accesses whose address does not meet the alignment rule, and a misaligned store changes nothing.

Top module: `dmem_port`

## Requirements
- R1: After reset every word of the array reads as zero.
- R2: Control code 11 with an address whose two low bits are 00 stores the whole write data word. A later word load of that word returns it.
- R3: Control code 01 stores write data bits 7:0 at any byte address. Byte offset 0 lands in word bits 31:24, offset 1 in 23:16, offset 2 in 15:8 and offset 3 in 7:0. The other three bytes keep their values.
- R4: Control code 10 stores write data bits 15:0. Offset 0 goes to bits 31:16 and offset 2 goes to bits 15:0. The other halfword keeps its value.
- R5: Load type encoding: 0 is a word load, 1 a signed byte, 2 an unsigned byte, 3 a signed halfword and 4 an unsigned halfword; codes 5 to 7 act as a word load. A signed byte load returns the byte at the big-endian offset, with bit 7 copied into bits 31:8.
- R6: Unsigned byte and halfword loads return the selected value with all upper bits zero.
- R7: A signed halfword load returns the halfword chosen by address bit 1 (0 selects bits 31:16), with bit 15 copied into bits 31:16. Address bit 0 does not take part in the selection.
- R8: While enable is high, the misalignment flag is raised for these cases: a word load or word store whose address bits 1:0 are not 00, and a halfword load or halfword store whose address bit 0 is 1. In every other case the flag is low.
- R9: A store that raises the misalignment flag leaves the addressed word unchanged.
- R10: With enable low, nothing is stored, the load value is zero and the misalignment flag is low.
- R11: The load value is zero whenever the control code is not 00. With code 00 it reflects the array contents combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears the array |
| en_i | input | 1 | Access enable |
| addr_i | input | ADDR_W | Byte address |
| ctrl_i | input | 2 | Memory control code (00 read, 01 byte store, 10 halfword store, 11 word store) |
| wdata_i | input | 32 | Store data, low bits used for sub-word stores |
| ltype_i | input | 3 | Load type for extraction |
| ldata_o | output | 32 | Extracted and extended load value |
| misalign_o | output | 1 | Alignment violation for the current access |

## Verification
Directed sequences store known patterns at each of the four byte offsets and at both halfword offsets. Word reads then tell a correct big-endian lane mapping from a mirrored or shifted one, and show that neighbouring bytes survive. Loads of values with the top bit set and clear, under each of the five load types, separate sign extension from zero extension and catch a wrong halfword select. Misaligned stores followed by word reads confirm that the flag suppresses the write, and operations with enable low confirm that they have no effect. A long constrained-random mix of stores and loads over a small address window is compared against a bench model of the array, which exposes lane or offset slips that the directed cases miss.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        MC_READ  = 2'b00,
        MC_WBYTE = 2'b01,
        MC_WHALF = 2'b10,
        MC_WWORD = 2'b11
    } mem_ctl_e;

    typedef enum logic [2:0] {
        LD_WORD = 3'd0,
        LD_BS   = 3'd1,
        LD_BU   = 3'd2,
        LD_HS   = 3'd3,
        LD_HU   = 3'd4
    } ld_kind_e;

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] lane_data;
        logic              misalign;
    } wr_req_t;

endpackage

// File: rtl/dmem_wr_lanes.sv
module dmem_wr_lanes
    import dmem_pkg::*;
(
    input  logic              en,
    input  logic [1:0]        ctrl,
    input  logic [1:0]        off,
    input  logic [2:0]        ltype,
    input  logic [WORD_W-1:0] wdata,
    output wr_req_t           req
);

    mem_ctl_e ctl;
    ld_kind_e kind;
    logic     bad_word;
    logic     bad_half;

    always_comb begin
        ctl      = mem_ctl_e'(ctrl);
        kind     = ld_kind_e'(ltype);
        bad_word = (off != 2'b00);
        bad_half = off[0];

        req.be        = '0;
        req.lane_data = wdata;
        req.misalign  = 1'b0;

        if (en) begin
            unique case (ctl)
                MC_READ: begin
                    if (kind == LD_HS || kind == LD_HU)
                        req.misalign = bad_half;
                    else if (kind == LD_BS || kind == LD_BU)
                        req.misalign = 1'b0;
                    else
                        req.misalign = bad_word;
                end
                MC_WBYTE: begin
                    req.lane_data     = {LANES{wdata[7:0]}};
                    // big-endian: offset 0 is the top lane
                    req.be[3 - off]   = 1'b1;
                end
                MC_WHALF: begin
                    req.lane_data = {2{wdata[15:0]}};
                    req.misalign  = bad_half;
                    if (!bad_half)
                        req.be = off[1] ? 4'b0011 : 4'b1100;
                end
                MC_WWORD: begin
                    req.misalign = bad_word;
                    if (!bad_word)
                        req.be = 4'b1111;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmem_array.sv
module dmem_array
    import dmem_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int WORDS = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  be,
    input  logic [WORD_W-1:0] lane_data,
    output logic [WORD_W-1:0] rword
);

    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] mem;
    } arr_st_t;

    arr_st_t            st_d;
    arr_st_t            st_q;
    logic [WORD_W-1:0]  cur_word;
    logic [WORD_W-1:0]  merged;

    assign cur_word = st_q.mem[idx];
    assign rword    = cur_word;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged[k*8 +: 8] = be[k] ? lane_data[k*8 +: 8] : cur_word[k*8 +: 8];
    end

    always_comb begin
        st_d = st_q;
        if (|be)
            st_d.mem[idx] = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/dmem_load_ext.sv
module dmem_load_ext
    import dmem_pkg::*;
(
    input  logic              rd_act,
    input  logic [1:0]        off,
    input  logic [2:0]        ltype,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] ldata
);

    logic [7:0]  sel_byte;
    logic [15:0] sel_half;
    ld_kind_e    kind;

    always_comb begin
        kind = ld_kind_e'(ltype);
        unique case (off)
            2'd0: sel_byte = word[31:24];
            2'd1: sel_byte = word[23:16];
            2'd2: sel_byte = word[15:8];
            default: sel_byte = word[7:0];
        endcase
        sel_half = off[1] ? word[15:0] : word[31:16];

        ldata = '0;
        if (rd_act) begin
            case (kind)
                LD_BS:   ldata = {{24{sel_byte[7]}}, sel_byte};
                LD_BU:   ldata = {24'd0, sel_byte};
                LD_HS:   ldata = {{16{sel_half[15]}}, sel_half};
                LD_HU:   ldata = {16'd0, sel_half};
                default: ldata = word;
            endcase
        end
    end

endmodule

// File: rtl/dmem_port.sv
module dmem_port
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        ctrl_i,
    input  logic [31:0]       wdata_i,
    input  logic [2:0]        ltype_i,
    output logic [31:0]       ldata_o,
    output logic              misalign_o
);

    wr_req_t           req;
    logic [WORD_W-1:0] rword;
    logic              rd_act;

    assign rd_act = en_i && (ctrl_i == MC_READ);

    dmem_wr_lanes u_lanes (
        .en    (en_i),
        .ctrl  (ctrl_i),
        .off   (addr_i[1:0]),
        .ltype (ltype_i),
        .wdata (wdata_i),
        .req   (req)
    );

    dmem_array #(.IDX_W(IDX_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (addr_i[ADDR_W-1:2]),
        .be        (req.be),
        .lane_data (req.lane_data),
        .rword     (rword)
    );

    dmem_load_ext u_ext (
        .rd_act (rd_act),
        .off    (addr_i[1:0]),
        .ltype  (ltype_i),
        .word   (rword),
        .ldata  (ldata_o)
    );

    assign misalign_o = req.misalign;

endmodule

// File: rtl/dmem_port_chk.sv
module dmem_port_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [1:0]        ctrl_i,
    input logic [31:0]       wdata_i,
    input logic [2:0]        ltype_i,
    input logic [31:0]       ldata_o,
    input logic              misalign_o
);

    a_r2_store_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ctrl_i == 2'b00 && ltype_i == 3'd0 && addr_i == $past(addr_i)
         && $past(en_i && ctrl_i == 2'b11 && addr_i[1:0] == 2'b00))
        |-> ldata_o == $past(wdata_i));

    a_r5_byte_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ctrl_i == 2'b00 && ltype_i == 3'd1) |-> ldata_o[31:8] == {24{ldata_o[7]}});

    a_r6_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ctrl_i == 2'b00 && (ltype_i == 3'd2 || ltype_i == 3'd4))
        |-> ldata_o[31:16] == 16'd0 && (ltype_i == 3'd4 || ldata_o[15:8] == 8'd0));

    a_r7_half_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ctrl_i == 2'b00 && ltype_i == 3'd3) |-> ldata_o[31:16] == {16{ldata_o[15]}});

    a_r8_byte_never_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i == 2'b01 || (ctrl_i == 2'b00 && (ltype_i == 3'd1 || ltype_i == 3'd2)))
        |-> !misalign_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (ldata_o == 32'd0 && !misalign_o));

    a_r11_store_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i != 2'b00) |-> ldata_o == 32'd0);

endmodule

bind dmem_port dmem_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .addr_i     (addr_i),
    .ctrl_i     (ctrl_i),
    .wdata_i    (wdata_i),
    .ltype_i    (ltype_i),
    .ldata_o    (ldata_o),
    .misalign_o (misalign_o)
);

// File: tb/tb_dmem_port.sv
module tb_dmem_port;

    localparam int ADDR_W = 8;
    localparam int WORDS  = 1 << (ADDR_W - 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [1:0]        ctrl_i = '0;
    logic [31:0]       wdata_i = '0;
    logic [2:0]        ltype_i = '0;
    logic [31:0]       ldata_o;
    logic              misalign_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] model [WORDS];

    always #2 clk = ~clk;

    dmem_port #(.ADDR_W(ADDR_W)) dut (.*);

    function automatic logic [31:0] exp_load(logic [31:0] w, logic [1:0] off, logic [2:0] lt);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[31 - 8*off -: 8];
        h = off[1] ? w[15:0] : w[31:16];
        case (lt)
            3'd1: return {{24{b[7]}}, b};
            3'd2: return {24'd0, b};
            3'd3: return {{16{h[15]}}, h};
            3'd4: return {16'd0, h};
            default: return w;
        endcase
    endfunction

    function automatic logic exp_mis(logic en, logic [1:0] c, logic [1:0] off, logic [2:0] lt);
        if (!en) return 1'b0;
        case (c)
            2'b00: begin
                if (lt == 3'd1 || lt == 3'd2) return 1'b0;
                if (lt == 3'd3 || lt == 3'd4) return off[0];
                return off != 2'b00;
            end
            2'b10: return off[0];
            2'b11: return off != 2'b00;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one access at the falling edge, check the combinational
    // outputs, then update the model for the commit at the next rising edge
    task automatic op(string tag, logic en, logic [ADDR_W-1:0] a, logic [1:0] c,
                      logic [31:0] wd, logic [2:0] lt);
        int idx;
        logic [1:0] off;
        logic m;
        logic [31:0] w;
        @(negedge clk);
        en_i = en; addr_i = a; ctrl_i = c; wdata_i = wd; ltype_i = lt;
        idx = int'(a[ADDR_W-1:2]);
        off = a[1:0];
        m = exp_mis(en, c, off, lt);
        #1;
        check({tag, " load"}, ldata_o, (en && c == 2'b00) ? exp_load(model[idx], off, lt) : 32'd0);
        check({tag, " flag"}, {31'd0, misalign_o}, {31'd0, m});
        if (en && !m) begin
            w = model[idx];
            case (c)
                2'b01: w[31 - 8*off -: 8] = wd[7:0];
                2'b10: if (off[1]) w[15:0] = wd[15:0]; else w[31:16] = wd[15:0];
                2'b11: w = wd;
                default: ;
            endcase
            model[idx] = w;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < WORDS; i++) model[i] = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < WORDS; i++) model[i] = 32'd0;

        // R1: every word zero after reset
        for (int i = 0; i < WORDS; i++)
            op("R1", 1'b1, ADDR_W'(i * 4), 2'b00, 32'd0, 3'd0);

        // R2: word store then word load
        op("R2", 1'b1, 8'h10, 2'b11, 32'h1234_5678, 3'd0);
        op("R2", 1'b1, 8'h10, 2'b00, 32'd0, 3'd0);

        // R3: byte stores at each offset, big-endian lanes
        op("R3", 1'b1, 8'h20, 2'b11, 32'hAABB_CCDD, 3'd0);
        op("R3", 1'b1, 8'h21, 2'b01, 32'hFFFF_FF11, 3'd0);
        op("R3", 1'b1, 8'h20, 2'b00, 32'd0, 3'd0);
        op("R3", 1'b1, 8'h23, 2'b01, 32'h0000_0022, 3'd0);
        op("R3", 1'b1, 8'h20, 2'b01, 32'h0000_0033, 3'd0);
        op("R3", 1'b1, 8'h22, 2'b01, 32'h0000_0044, 3'd0);
        op("R3", 1'b1, 8'h20, 2'b00, 32'd0, 3'd0);

        // R4: halfword stores at both halves
        op("R4", 1'b1, 8'h30, 2'b11, 32'h0102_0304, 3'd0);
        op("R4", 1'b1, 8'h32, 2'b10, 32'hDEAD_BEEF, 3'd0);
        op("R4", 1'b1, 8'h30, 2'b00, 32'd0, 3'd0);
        op("R4", 1'b1, 8'h30, 2'b10, 32'h0000_CAFE, 3'd0);
        op("R4", 1'b1, 8'h30, 2'b00, 32'd0, 3'd0);

        // R5/R6/R7: extension forms on a word with mixed sign bits
        op("R5", 1'b1, 8'h40, 2'b11, 32'h80_7F_F0_05, 3'd0);
        for (int o = 0; o < 4; o++) begin
            op("R5", 1'b1, 8'h40 + ADDR_W'(o), 2'b00, 32'd0, 3'd1);
            op("R6", 1'b1, 8'h40 + ADDR_W'(o), 2'b00, 32'd0, 3'd2);
        end
        op("R7", 1'b1, 8'h40, 2'b00, 32'd0, 3'd3);
        op("R7", 1'b1, 8'h42, 2'b00, 32'd0, 3'd3);
        op("R6", 1'b1, 8'h40, 2'b00, 32'd0, 3'd4);
        op("R6", 1'b1, 8'h42, 2'b00, 32'd0, 3'd4);
        op("R5", 1'b1, 8'h40, 2'b00, 32'd0, 3'd6);

        // R8/R9: misaligned accesses flag and do not store
        op("R9", 1'b1, 8'h51, 2'b11, 32'h9999_9999, 3'd0);
        op("R9", 1'b1, 8'h53, 2'b10, 32'h7777_7777, 3'd0);
        op("R9", 1'b1, 8'h50, 2'b00, 32'd0, 3'd0);
        op("R8", 1'b1, 8'h52, 2'b00, 32'd0, 3'd0);
        op("R8", 1'b1, 8'h41, 2'b00, 32'd0, 3'd3);

        // R10: disabled accesses change nothing
        op("R10", 1'b0, 8'h10, 2'b11, 32'h5555_5555, 3'd0);
        op("R10", 1'b0, 8'h11, 2'b00, 32'd0, 3'd0);
        op("R10", 1'b1, 8'h10, 2'b00, 32'd0, 3'd0);

        // R11: load value held at zero during stores
        op("R11", 1'b1, 8'h40, 2'b01, 32'h0000_00AA, 3'd1);
        op("R11", 1'b1, 8'h40, 2'b00, 32'd0, 3'd0);

        // random mix over a small window to force collisions
        for (int n = 0; n < 3000; n++) begin
            logic [ADDR_W-1:0] a;
            logic [1:0] c;
            logic [2:0] lt;
            logic e;
            a  = ADDR_W'($urandom_range(0, 31));
            c  = 2'($urandom_range(0, 3));
            lt = 3'($urandom_range(0, 7));
            e  = ($urandom_range(0, 9) != 0);
            op("R11 random", e, a, c, $urandom, lt);
        end

        @(negedge clk);
        en_i = 1'b0;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule